// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface Model

This block models the device side of a parallel NOR flash. It watches single-cycle writes on an address/data bus and decodes unlock-prefixed command sequences for word program, sector erase and chip erase. Once a sequence completes, an internal embedded algorithm runs for a set number of clock cycles. During that time the ready/busy output is low, and reads return a status word in place of array data. At the end, the operation is applied to a small internal word array.

An erase that is running can be suspended and later resumed. While suspended, reads outside the sector being erased return array data. A write-protect input guards the lowest and highest sectors, and a per-sector lock vector guards any sector. The asynchronous active-low reset acts as the hardware reset: it aborts any operation and returns the model to read mode.

The array holds 2^ARR_AW words, divided into sectors of 2^SECT_AW words each. The sector index is taken from addr[ARR_AW-1:SECT_AW]. Unlock addresses are compared on the full bus address. Command codes are compared on wdata[7:0].

Top module: `pflash_cmd_model`

## Requirements
- R1: The four writes AAh@555h, 55h@2AAh, A0h@555h, then D@A start a program. busy_n is low for exactly PROG_CYC cycles. Afterwards the word at A reads as its old value AND D, so a program can only clear bits.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h to any address in a sector start a sector erase. busy_n is low for exactly ERASE_CYC cycles. Afterwards every word of that sector reads FFFFh, and other sectors are unchanged.
- R3: The same prefix ending with 10h@555h erases every sector that is not denied. busy_n is low for ERASE_CYC cycles.
- R4: A write that breaks the expected sequence returns the decoder to read mode. busy_n stays high, the array is unchanged, and a later correct sequence still works.
- R5: busy_n falls only in the cycle after the final write of an accepted sequence, and rises when the algorithm ends.
- R6: While a program or erase runs, a read at any address returns a status word. Bit 7 is the complement of the programmed bit 7 (0 during erase). Every bit other than 7, 6 and 2 reads 0. After completion, reads return true array data.
- R7: Status bit 6 inverts on every status read while a program or erase runs. Reads of array data after completion are stable.
- R8: Writing B0h during an erase suspends it, and busy_n goes high. Reads outside the erasing sector return array data. Reads inside it return status with bit 7 = 1, bit 6 steady and bit 2 inverting on each read. Writing 30h resumes the erase, and the total busy time stays ERASE_CYC.
- R9: With wp_n low, program and sector erase aimed at sector 0 or the last sector are ignored (busy_n stays high, data kept). Chip erase skips those two sectors.
- R10: A set sect_lock bit makes program and sector erase of that sector ignored. Chip erase skips that sector.
- R11: rst_n low aborts any operation. After release, busy_n is high, rdata is 0, and an aborted erase leaves its sector's data unchanged.
- R12: rdata changes only at a clock edge that samples rd_en high with wr_en low, one cycle after the request. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | BAW (12) | Bus word address |
| wdata | input | DW (16) | Write data; command code in bits 7:0 |
| wp_n | input | 1 | Active-low write protect for the two outermost sectors |
| sect_lock | input | NSECT (8) | Per-sector lock, 1 = protected |
| rdata | output | DW (16) | Registered read data or status word |
| busy_n | output | 1 | Low while an embedded algorithm runs |

## Verification
The state hardest to reach from the ports is a suspended erase. To get there, a full six-write erase must be accepted, a fixed number of busy cycles must be counted, and the suspend code must land before the counter expires. Reads must then alternate between the suspended sector and a neighbour, so that status and array data can be told apart. The directed stimulus counts cycles at the falling edge. It issues the suspend after a known number of busy cycles and then resumes. It checks that the busy cycles before and after the suspend add up to the full erase time, and that the target sector reads all ones afterwards.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  typedef enum logic [1:0] {
    ENG_READ  = 2'd0,
    ENG_PROG  = 2'd1,
    ENG_ERASE = 2'd2,
    ENG_SUSP  = 2'd3
  } eng_t;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U1   = 3'd1,
    SQ_U2   = 3'd2,
    SQ_PGM  = 3'd3,
    SQ_E1   = 3'd4,
    SQ_E2   = 3'd5,
    SQ_E3   = 3'd6
  } seq_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERSET  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_PAUSE  = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;

endpackage

// File: rtl/pfl_rst_sync.sv
module pfl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/pfl_seq_decode.sv
module pfl_seq_decode
  import pfl_pkg::*;
#(
  parameter int          BAW    = 12,
  parameter logic [11:0] UNLK_A = 12'h555,
  parameter logic [11:0] UNLK_B = 12'h2AA
) (
  input  logic           clk,
  input  logic           rst_sn,
  input  logic           wr_en,
  input  logic [BAW-1:0] addr,
  input  logic [7:0]     cmd,
  input  eng_t           mode,
  output logic           prog_go,
  output logic           sect_go,
  output logic           chip_go,
  output logic           sus_go,
  output logic           res_go
);
  seq_t sq_q, sq_n;
  logic at_a, at_b;

  assign at_a = (addr == BAW'(UNLK_A));
  assign at_b = (addr == BAW'(UNLK_B));

  always_comb begin
    sq_n    = sq_q;
    prog_go = 1'b0;
    sect_go = 1'b0;
    chip_go = 1'b0;
    sus_go  = 1'b0;
    res_go  = 1'b0;
    if (mode != ENG_READ) begin
      sq_n   = SQ_IDLE;
      sus_go = wr_en && (mode == ENG_ERASE) && (cmd == CMD_PAUSE);
      res_go = wr_en && (mode == ENG_SUSP)  && (cmd == CMD_RESUME);
    end else if (wr_en) begin
      unique case (sq_q)
        SQ_IDLE: sq_n = (cmd == CMD_KEY1 && at_a) ? SQ_U1 : SQ_IDLE;
        SQ_U1:   sq_n = (cmd == CMD_KEY2 && at_b) ? SQ_U2 : SQ_IDLE;
        SQ_U2: begin
          if (cmd == CMD_PROG && at_a)       sq_n = SQ_PGM;
          else if (cmd == CMD_ERSET && at_a) sq_n = SQ_E1;
          else                               sq_n = SQ_IDLE;
        end
        SQ_PGM: begin
          prog_go = 1'b1;
          sq_n    = SQ_IDLE;
        end
        SQ_E1:   sq_n = (cmd == CMD_KEY1 && at_a) ? SQ_E2 : SQ_IDLE;
        SQ_E2:   sq_n = (cmd == CMD_KEY2 && at_b) ? SQ_E3 : SQ_IDLE;
        SQ_E3: begin
          sect_go = (cmd == CMD_SECT);
          chip_go = (cmd == CMD_CHIP) && at_a;
          sq_n    = SQ_IDLE;
        end
        default: sq_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sq_q <= SQ_IDLE;
    else         sq_q <= sq_n;
  end
endmodule

// File: rtl/pfl_status_gen.sv
module pfl_status_gen
  import pfl_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          rd_stat,
  input  eng_t          mode,
  input  logic          p_msb,
  output logic [DW-1:0] stat_word
);
  logic t6_q, t6_n, t2_q, t2_n;

  always_comb begin
    t6_n = t6_q;
    t2_n = t2_q;
    if (rd_stat) begin
      if (mode == ENG_SUSP) t2_n = ~t2_q;
      else                  t6_n = ~t6_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else if (rd_stat) begin
      t6_q <= t6_n;
      t2_q <= t2_n;
    end
  end

  always_comb begin
    stat_word    = '0;
    stat_word[7] = (mode == ENG_PROG) ? ~p_msb : (mode == ENG_SUSP);
    stat_word[6] = t6_q;
    stat_word[2] = t2_q;
  end
endmodule

// File: rtl/pfl_word_array.sv
module pfl_word_array #(
  parameter int DW      = 16,
  parameter int ARR_AW  = 6,
  parameter int SECT_AW = 3
) (
  input  logic                      clk,
  input  logic [ARR_AW-1:0]         rd_addr,
  output logic [DW-1:0]             rd_word,
  input  logic                      pg_en,
  input  logic [ARR_AW-1:0]         pg_addr,
  input  logic [DW-1:0]             pg_data,
  input  logic                      er_en,
  input  logic [(1<<(ARR_AW-SECT_AW))-1:0] er_mask
);
  localparam int DEPTH = 1 << ARR_AW;
  localparam int WPS   = 1 << SECT_AW;

  logic [DEPTH*DW-1:0] flat;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    localparam int SI = gi / WPS;
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (er_en && er_mask[SI])                       q <= '1;
      else if (pg_en && pg_addr == ARR_AW'(gi))       q <= q & pg_data;
    end
    assign flat[gi*DW +: DW] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == ARR_AW'(i)) rd_word = flat[i*DW +: DW];
    end
  end
endmodule

// File: rtl/pflash_cmd_model.sv
module pflash_cmd_model
  import pfl_pkg::*;
#(
  parameter int          BAW       = 12,
  parameter int          DW        = 16,
  parameter int          ARR_AW    = 6,
  parameter int          SECT_AW   = 3,
  parameter int          PROG_CYC  = 12,
  parameter int          ERASE_CYC = 40,
  parameter logic [11:0] UNLK_A    = 12'h555,
  parameter logic [11:0] UNLK_B    = 12'h2AA
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic                               rd_en,
  input  logic [BAW-1:0]                     addr,
  input  logic [DW-1:0]                      wdata,
  input  logic                               wp_n,
  input  logic [(1<<(ARR_AW-SECT_AW))-1:0]   sect_lock,
  output logic [DW-1:0]                      rdata,
  output logic                               busy_n
);
  localparam int SW      = ARR_AW - SECT_AW;
  localparam int NSECT   = 1 << SW;
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [NSECT-1:0] BOOT = (NSECT'(1) << (NSECT-1)) | NSECT'(1);

  logic rst_sn;
  eng_t st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_init;
  logic cnt_ld, cnt_dec;
  logic [ARR_AW-1:0] pa_q;
  logic [DW-1:0] pd_q;
  logic [NSECT-1:0] em_q, ers_sel;
  logic ld_prog, ld_ers, pg_fire, er_fire;
  logic prog_go, sect_go, chip_go, sus_go, res_go;
  logic [SW-1:0] sec;
  logic [NSECT-1:0] deny, tgt_1h, chip_sel;
  logic rd_fire, stat_sel, rd_stat;
  logic [DW-1:0] stat_word, arr_word;

  pfl_rst_sync u_rs (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  pfl_seq_decode #(.BAW(BAW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_dec (
    .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .addr(addr), .cmd(wdata[7:0]),
    .mode(st_q), .prog_go(prog_go), .sect_go(sect_go), .chip_go(chip_go),
    .sus_go(sus_go), .res_go(res_go)
  );

  assign sec      = addr[ARR_AW-1:SECT_AW];
  assign deny     = sect_lock | (wp_n ? '0 : BOOT);
  assign tgt_1h   = NSECT'(1) << sec;
  assign chip_sel = ~deny;

  // Embedded algorithm sequencer: next state
  always_comb begin
    st_n     = st_q;
    cnt_ld   = 1'b0;
    cnt_dec  = 1'b0;
    cnt_init = '0;
    ld_prog  = 1'b0;
    ld_ers   = 1'b0;
    ers_sel  = '0;
    pg_fire  = 1'b0;
    er_fire  = 1'b0;
    unique case (st_q)
      ENG_READ: begin
        if (prog_go && !deny[sec]) begin
          st_n     = ENG_PROG;
          cnt_ld   = 1'b1;
          cnt_init = CW'(PROG_CYC - 1);
          ld_prog  = 1'b1;
        end else if (sect_go && !deny[sec]) begin
          st_n     = ENG_ERASE;
          cnt_ld   = 1'b1;
          cnt_init = CW'(ERASE_CYC - 1);
          ld_ers   = 1'b1;
          ers_sel  = tgt_1h;
        end else if (chip_go && (|chip_sel)) begin
          st_n     = ENG_ERASE;
          cnt_ld   = 1'b1;
          cnt_init = CW'(ERASE_CYC - 1);
          ld_ers   = 1'b1;
          ers_sel  = chip_sel;
        end
      end
      ENG_PROG: begin
        if (cnt_q == '0) begin
          pg_fire = 1'b1;
          st_n    = ENG_READ;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ENG_ERASE: begin
        if (cnt_q == '0) begin
          er_fire = 1'b1;
          st_n    = ENG_READ;
        end else begin
          cnt_dec = 1'b1;
          if (sus_go) st_n = ENG_SUSP;
        end
      end
      ENG_SUSP: if (res_go) st_n = ENG_ERASE;
      default:  st_n = ENG_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= ENG_READ;
    else         st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      cnt_q <= '0;
    else if (cnt_ld)  cnt_q <= cnt_init;
    else if (cnt_dec) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pa_q <= '0;
      pd_q <= '0;
    end else if (ld_prog) begin
      pa_q <= addr[ARR_AW-1:0];
      pd_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     em_q <= '0;
    else if (ld_ers) em_q <= ers_sel;
  end

  pfl_word_array #(.DW(DW), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .rd_addr(addr[ARR_AW-1:0]), .rd_word(arr_word),
    .pg_en(pg_fire), .pg_addr(pa_q), .pg_data(pd_q),
    .er_en(er_fire), .er_mask(em_q)
  );

  // Read path
  assign rd_fire  = rd_en && !wr_en;
  assign stat_sel = (st_q == ENG_PROG) || (st_q == ENG_ERASE) ||
                    ((st_q == ENG_SUSP) && em_q[sec]);
  assign rd_stat  = rd_fire && stat_sel;

  pfl_status_gen #(.DW(DW)) u_stat (
    .clk(clk), .rst_sn(rst_sn), .rd_stat(rd_stat), .mode(st_q),
    .p_msb(pd_q[7]), .stat_word(stat_word)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      rdata <= '0;
    else if (rd_fire) rdata <= stat_sel ? stat_word : arr_word;
  end

  assign busy_n = !((st_q == ENG_PROG) || (st_q == ENG_ERASE));
endmodule

// File: rtl/pfl_sva.sv
module pfl_sva #(
  parameter int BAW     = 12,
  parameter int DW      = 16,
  parameter int ARR_AW  = 6,
  parameter int SECT_AW = 3
) (
  input logic                               clk,
  input logic                               rst_sn,
  input logic                               wr_en,
  input logic                               rd_en,
  input logic [ARR_AW-1:0]                  addr,
  input logic [7:0]                         cmd,
  input logic                               wp_n,
  input logic [(1<<(ARR_AW-SECT_AW))-1:0]   sect_lock,
  input logic [DW-1:0]                      rdata,
  input logic                               busy_n
);
  localparam int SW    = ARR_AW - SECT_AW;
  localparam int NSECT = 1 << SW;

  logic [SW-1:0] sec;
  logic boot;
  assign sec  = addr[ARR_AW-1:SECT_AW];
  assign boot = (sec == '0) || (sec == SW'(NSECT-1));

  // R5: busy only begins right after a bus write
  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy_n) |-> $past(wr_en));

  // R9: no busy start aimed at a boot sector while protected (chip erase excluded)
  a_r9_boot_guard: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(busy_n) && $past(cmd) != 8'h10) |-> !(!$past(wp_n) && $past(boot)));

  // R10: no busy start aimed at a locked sector (chip erase excluded)
  a_r10_lock_guard: assert property (@(posedge clk) disable iff (!rst_sn)
    ($fell(busy_n) && $past(cmd) != 8'h10) |-> !$past(sect_lock[sec]));

  // R6: reserved status bits read zero while busy
  a_r6_status_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy_n && rd_en && !wr_en) |=> (rdata[DW-1:8] == '0 && rdata[5:3] == 3'b0 && rdata[1:0] == 2'b0));

  // R7: back-to-back status reads invert bit 6
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(!busy_n && rd_en && !wr_en) && !busy_n && rd_en && !wr_en) |=> (rdata[6] != $past(rdata[6])));

  // R12: read data holds without a read request
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rd_en && !wr_en) |=> $stable(rdata));
endmodule

bind pflash_cmd_model pfl_sva #(.BAW(BAW), .DW(DW), .ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_sva (
  .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .rd_en(rd_en), .addr(addr[ARR_AW-1:0]),
  .cmd(wdata[7:0]), .wp_n(wp_n), .sect_lock(sect_lock), .rdata(rdata), .busy_n(busy_n)
);

// File: tb/sim_pflash_cmd_model.sv
module sim_pflash_cmd_model;
  localparam int PC = 12;
  localparam int EC = 40;

  logic clk, rst_n, wr_en, rd_en, wp_n, busy_n;
  logic [11:0] addr;
  logic [15:0] wdata, rdata;
  logic [7:0]  sect_lock;
  int checks, errors;

  pflash_cmd_model #(.PROG_CYC(PC), .ERASE_CYC(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wp_n(wp_n), .sect_lock(sect_lock), .rdata(rdata), .busy_n(busy_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic unlock();
    bus_wr(12'h555, 16'h00AA);
    bus_wr(12'h2AA, 16'h0055);
  endtask

  task automatic do_prog(input logic [11:0] a, input logic [15:0] d);
    unlock(); bus_wr(12'h555, 16'h00A0); bus_wr(a, d);
  endtask

  task automatic erase_pre();
    unlock(); bus_wr(12'h555, 16'h0080); unlock();
  endtask

  task automatic do_sect(input logic [11:0] a);
    erase_pre(); bus_wr(a, 16'h0030);
  endtask

  task automatic do_chip();
    erase_pre(); bus_wr(12'h555, 16'h0010);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!busy_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R11 busy_n after reset", 32'(busy_n), 32'd1);
    check("R11 rdata after reset", 32'(rdata), 32'h0);
  endtask

  task automatic t_chip_init();
    int n; logic [15:0] d;
    do_chip();
    wait_ready(n);
    check("R3 chip erase busy cycles", n, EC);
    bus_rd(12'h000, d); check("R3 word 0 erased", d, 32'hFFFF);
    bus_rd(12'h03F, d); check("R3 last word erased", d, 32'hFFFF);
  endtask

  task automatic t_program();
    int n; logic [15:0] d;
    do_prog(12'h009, 16'h1234);
    check("R5 busy low after final write", 32'(busy_n), 32'd0);
    wait_ready(n);
    check("R1 program busy cycles", n, PC);
    bus_rd(12'h009, d); check("R1 programmed word", d, 32'h1234);
    do_prog(12'h009, 16'hFF0F); wait_ready(n);
    bus_rd(12'h009, d); check("R1 program clears only", d, 32'h1204);
    do_prog(12'h010, 16'h5555); wait_ready(n);
  endtask

  task automatic t_status();
    int n; logic [15:0] s1, s2, d1, d2;
    do_prog(12'h00A, 16'h0080);
    bus_rd(12'h030, s1);
    bus_rd(12'h00A, s2);
    check("R6 status bit7 complement", 32'(s1[7]), 32'd0);
    check("R6 reserved status bits", 32'(s1 & 16'hFF3B), 32'h0);
    check("R7 bit6 inverts", 32'(s1[6] ^ s2[6]), 32'd1);
    wait_ready(n);
    bus_rd(12'h00A, d1); bus_rd(12'h00A, d2);
    check("R6 true data after done", d1, 32'h0080);
    check("R7 stable after done", d2, 32'(d1));
  endtask

  task automatic t_broken();
    int n; logic [15:0] d;
    unlock(); bus_wr(12'h556, 16'h00A0); bus_wr(12'h00B, 16'h0000);
    check("R4 no busy on broken sequence", 32'(busy_n), 32'd1);
    bus_rd(12'h00B, d); check("R4 array untouched", d, 32'hFFFF);
    do_prog(12'h00B, 16'h00FF); wait_ready(n);
    bus_rd(12'h00B, d); check("R4 later sequence works", d, 32'h00FF);
  endtask

  task automatic t_sector();
    int n; logic [15:0] d;
    do_sect(12'h00C);
    wait_ready(n);
    check("R2 sector erase busy cycles", n, EC);
    bus_rd(12'h009, d); check("R2 sector word erased", d, 32'hFFFF);
    bus_rd(12'h00B, d); check("R2 sector word erased 2", d, 32'hFFFF);
    bus_rd(12'h010, d); check("R2 neighbour kept", d, 32'h5555);
  endtask

  task automatic t_suspend();
    int n, k; logic [15:0] d, s1, s2;
    do_prog(12'h011, 16'h00F0); wait_ready(n);
    do_sect(12'h012);
    k = 0;
    repeat (5) begin
      if (!busy_n) k++;
      @(negedge clk);
    end
    if (!busy_n) k++;
    bus_wr(12'h000, 16'h00B0);
    check("R8 ready while suspended", 32'(busy_n), 32'd1);
    bus_rd(12'h009, d); check("R8 outside sector reads array", d, 32'hFFFF);
    bus_rd(12'h011, s1); bus_rd(12'h011, s2);
    check("R8 suspended status bit7", 32'(s1[7]), 32'd1);
    check("R8 bit2 inverts", 32'(s1[2] ^ s2[2]), 32'd1);
    check("R8 bit6 steady", 32'(s1[6] ^ s2[6]), 32'd0);
    bus_wr(12'h000, 16'h0030);
    check("R8 busy after resume", 32'(busy_n), 32'd0);
    wait_ready(n);
    check("R8 total erase cycles", k + n, EC);
    bus_rd(12'h011, d); check("R8 erase completed", d, 32'hFFFF);
    bus_rd(12'h010, d); check("R8 erase completed 2", d, 32'hFFFF);
  endtask

  task automatic t_wp();
    int n; logic [15:0] d;
    do_prog(12'h002, 16'h1111); wait_ready(n);
    wp_n = 1'b0;
    do_prog(12'h001, 16'h0000);
    check("R9 sector0 program ignored", 32'(busy_n), 32'd1);
    do_prog(12'h03E, 16'h0000);
    check("R9 last sector program ignored", 32'(busy_n), 32'd1);
    bus_rd(12'h03E, d); check("R9 last sector data kept", d, 32'hFFFF);
    do_prog(12'h018, 16'h0000); wait_ready(n);
    bus_rd(12'h018, d); check("R9 other sector programmable", d, 32'h0000);
    do_chip(); wait_ready(n);
    bus_rd(12'h002, d); check("R9 chip erase skips boot", d, 32'h1111);
    bus_rd(12'h018, d); check("R9 chip erase others", d, 32'hFFFF);
    wp_n = 1'b1;
  endtask

  task automatic t_lock();
    int n; logic [15:0] d;
    do_prog(12'h020, 16'h0F0F); wait_ready(n);
    sect_lock = 8'h10;
    do_prog(12'h021, 16'h0000);
    check("R10 locked program ignored", 32'(busy_n), 32'd1);
    do_sect(12'h020);
    check("R10 locked erase ignored", 32'(busy_n), 32'd1);
    bus_rd(12'h021, d); check("R10 locked data kept", d, 32'hFFFF);
    bus_rd(12'h020, d); check("R10 locked data kept 2", d, 32'h0F0F);
    sect_lock = 8'h00;
  endtask

  task automatic t_reset_abort();
    int n; logic [15:0] d;
    do_prog(12'h028, 16'h00FF); wait_ready(n);
    do_sect(12'h029);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 ready after abort", 32'(busy_n), 32'd1);
    check("R11 rdata cleared", 32'(rdata), 32'h0);
    bus_rd(12'h028, d); check("R11 aborted erase kept data", d, 32'h00FF);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check("R12 rdata holds when idle", 32'(rdata), 32'h00FF);
    bus_wr(12'h028, 16'h1234);
    check("R12 rdata holds on write", 32'(rdata), 32'h00FF);
    check("R4 stray write no busy", 32'(busy_n), 32'd1);
    bus_rd(12'h02A, d); check("R12 read updates", d, 32'hFFFF);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    wp_n = 1'b1; sect_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_chip_init();
    t_program();
    t_status();
    t_broken();
    t_sector();
    t_suspend();
    t_wp();
    t_lock();
    t_reset_abort();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule